// File: doc/BRIEF.md
# Peripheral Clock Control Slot

This block is one control slot of a peripheral clock controller. It holds a single 32-bit control word for one peripheral. From eight candidate clock-enable inputs it picks one and divides it by an integer from 1 to 8. It gates the result and drives the peripheral's active-low reset. The output is a stream of single-cycle clock-enable pulses in the block's own clock domain. No clock is actually switched.

A simple bus port writes the whole word in one cycle and reads it back with one cycle of latency. Two input ports drive the present flag and the in-use lock. While the present flag is low or the lock is high, every write is refused. Source, fractional-mode and divider fields can change only while the gate bit is clear. A refused write changes nothing and sets a sticky error flag, which a read clears. Two parameters build slot variants without a source field or without a divider field. A slot without a source field always uses input 1. A slot without a divider field passes that source at its full rate.

Word layout: bit 31 present (read-only), bit 30 gate enable, bit 29 in-use (read-only), bit 28 reset release, bit 27 error flag (read-only, cleared on read), bits 26:24 source index, bit 3 fractional mode, bits 2:0 divisor minus one. All other bits read as 0.

Top module: `pclk_slot`

## Requirements
- R1: After reset the gate, source, fractional and divider fields and the reset-release bit are all 0, and the error flag is 0. The peripheral reset output is low and no output pulse is produced.
- R2: With source index 0 no output pulse is produced, whatever the eight inputs do. With any other index, inputs other than the selected one have no effect.
- R3: With the gate set and fractional mode off, one output pulse follows every (D+1)-th pulse of the selected input, where D is bits 2:0. The output pulse comes one cycle after the input pulse that completes the count. The count starts from zero whenever the gate is off.
- R4: With fractional mode set (bit 3 = 1), each group of D+1 selected input pulses gives two output pulses. The first follows input pulse number floor((D-1)/2) of the group, counted from 0, and the second follows the last pulse of the group. This gives a rate of parent×2/(D+1).
- R5: A write with bit 3 = 1 and bits 2:0 = 0 is refused.
- R6: While the gate bit is set, a write whose source, fractional or divider value differs from the stored one is refused. A write that changes only the gate or reset-release bit is accepted.
- R7: Any write is refused while the present input is low or the in-use input is high.
- R8: A refused write leaves every field and the reset output unchanged and sets bit 27. A read returns bit 27 and clears it, so the next read shows 0.
- R9: Bit 28 drives the peripheral reset output: 0 holds the peripheral in reset (output low), 1 releases it (output high).
- R10: The clock-enabled status output is high whenever the gate bit or the in-use input is high.
- R11: Bits 31 and 29 always read the present and in-use inputs. Bus writes to those bits have no effect.
- R12: A slot built without a source field refuses writes with a nonzero source index and uses input 1. A slot built without a divider field refuses writes with a nonzero bit 3 or bits 2:0, and passes the source at its full rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slotPresent | input | 1 | Present flag, seen as bit 31 |
| slotInUse | input | 1 | In-use lock, seen as bit 29 |
| srcEnIn | input | 8 | Candidate clock-enable inputs, index 0 unused |
| busWe | input | 1 | Write strobe for the control word |
| busRe | input | 1 | Read strobe, data follows one cycle later |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| clkEnOut | output | 1 | Gated, divided clock-enable pulses |
| periphRstN | output | 1 | Active-low peripheral reset |
| clkIsEnabled | output | 1 | Clock-enabled status |

## Verification
Read data is due in the cycle after the read strobe. A write changes the stored fields, the reset output and the status output at the next clock edge. An output pulse appears in the cycle after the input pulse that completes a count. The bench drives inputs on falling edges, so each result is sampled on the falling edge after the rising edge that produces it. Read results go through a queue of expected words, and the monitor pops one on the falling edge after each read strobe. For pulse trains, the bench counts output pulses over a whole number of divider periods and records the sample step of the first pulse. It then compares both with values worked out from the divisor and the fractional rule.

// File: rtl/pclk_slot_pkg.sv
package pclk_slot_pkg;
  localparam int SRC_COUNT = 8;
  localparam int SRC_W     = $clog2(SRC_COUNT);
  localparam int DIV_W     = 3;
  localparam int WORD_W    = 32;

  // control word bit positions
  localparam int B_PRESENT = 31;
  localparam int B_GATE    = 30;
  localparam int B_INUSE   = 29;
  localparam int B_RSTREL  = 28;
  localparam int B_ERR     = 27;
  localparam int B_SRC_LSB = 24;
  localparam int B_FRAC    = 3;
  localparam int B_DIV_LSB = 0;

  // strobes and settings handed from control to datapath
  typedef struct packed {
    logic             gateOn;
    logic [SRC_W-1:0] srcSel;
    logic             fracOn;
    logic [DIV_W-1:0] divM1;
  } slotCfg_t;
endpackage

// File: rtl/pclk_slot_ctrl.sv
module pclk_slot_ctrl
  import pclk_slot_pkg::*;
#(
  parameter bit HAS_SRC   = 1'b1,
  parameter bit HAS_DIV   = 1'b1,
  parameter int FIXED_SRC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slotPresent,
  input  logic              slotInUse,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  output logic              periphRstN,
  output logic              clkIsEnabled,
  output slotCfg_t          cfg
);
  logic             gateQ, rstRelQ, errQ, fracQ;
  logic [SRC_W-1:0] srcQ;
  logic [DIV_W-1:0] pcdQ;

  logic             wrGate, wrRst, wrFrac;
  logic [SRC_W-1:0] wrSrc;
  logic [DIV_W-1:0] wrPcd;
  logic             lockedOut, cfgChange, badSrc, badDiv, badCombo;
  logic             reject, accept;
  logic [WORD_W-1:0] readWord;

  assign wrGate = busWdata[B_GATE];
  assign wrRst  = busWdata[B_RSTREL];
  assign wrFrac = busWdata[B_FRAC];
  assign wrSrc  = busWdata[B_SRC_LSB +: SRC_W];
  assign wrPcd  = busWdata[B_DIV_LSB +: DIV_W];

  always_comb begin
    lockedOut = !slotPresent || slotInUse;
    cfgChange = (wrSrc != srcQ) || (wrFrac != fracQ) || (wrPcd != pcdQ);
    badSrc    = !HAS_SRC && (wrSrc != '0);
    badDiv    = !HAS_DIV && (wrFrac || (wrPcd != '0));
    badCombo  = wrFrac && (wrPcd == '0);
    reject    = busWe && (lockedOut || (gateQ && cfgChange) || badSrc || badDiv || badCombo);
    accept    = busWe && !reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gateQ   <= 1'b0;
      rstRelQ <= 1'b0;
      srcQ    <= '0;
      fracQ   <= 1'b0;
      pcdQ    <= '0;
    end else if (accept) begin
      gateQ   <= wrGate;
      rstRelQ <= wrRst;
      srcQ    <= wrSrc;
      fracQ   <= wrFrac;
      pcdQ    <= wrPcd;
    end
  end

  // sticky error: a refusal in the same cycle as a read wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      errQ <= 1'b0;
    else if (reject) errQ <= 1'b1;
    else if (busRe)  errQ <= 1'b0;
  end

  always_comb begin
    readWord            = '0;
    readWord[B_PRESENT] = slotPresent;
    readWord[B_GATE]    = gateQ;
    readWord[B_INUSE]   = slotInUse;
    readWord[B_RSTREL]  = rstRelQ;
    readWord[B_ERR]     = errQ;
    readWord[B_SRC_LSB +: SRC_W] = srcQ;
    readWord[B_FRAC]    = fracQ;
    readWord[B_DIV_LSB +: DIV_W] = pcdQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busRdata <= '0;
    else if (busRe) busRdata <= readWord;
  end

  assign periphRstN   = rstRelQ;
  assign clkIsEnabled = gateQ || slotInUse;

  generate
    if (HAS_SRC) begin : g_src
      assign cfg.srcSel = srcQ;
    end else begin : g_fixed
      assign cfg.srcSel = SRC_W'(FIXED_SRC);
    end
  endgenerate
  assign cfg.gateOn = gateQ;
  assign cfg.fracOn = fracQ;
  assign cfg.divM1  = pcdQ;

  // R6: configuration fields hold while the gate is on
  p_locked_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gateQ |=> (srcQ == $past(srcQ)) && (fracQ == $past(fracQ)) && (pcdQ == $past(pcdQ)));

  // R7, R8: locked slot keeps its state and flags the error
  p_reject_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && lockedOut) |=> ($stable({gateQ, rstRelQ, srcQ, fracQ, pcdQ}) && errQ));

  // R8: a read without a concurrent write clears the flag
  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busRe && !busWe) |=> !errQ);

  // R5: fractional mode never coexists with a divisor of one
  p_no_frac_div1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fracQ |-> (pcdQ != '0));
endmodule

// File: rtl/pclk_slot_div.sv
module pclk_slot_div
  import pclk_slot_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  slotCfg_t             cfg,
  input  logic [SRC_COUNT-1:0] srcEnIn,
  output logic                 clkEnOut
);
  logic [SRC_COUNT-1:0] srcLive;
  logic [DIV_W-1:0]     cnt;
  logic [DIV_W-1:0]     halfMark;
  logic                 parentHit, endHit, midHit;

  // index 0 is the "off" entry and never carries pulses
  generate
    for (genvar i = 0; i < SRC_COUNT; i++) begin : g_live
      if (i == 0) begin : g_off
        assign srcLive[i] = 1'b0;
      end else begin : g_on
        assign srcLive[i] = srcEnIn[i];
      end
    end
  endgenerate

  assign parentHit = srcLive[cfg.srcSel];
  assign halfMark  = (cfg.divM1 - DIV_W'(1)) >> 1;
  assign endHit    = (cnt == cfg.divM1);
  assign midHit    = cfg.fracOn && (cnt == halfMark);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      clkEnOut <= 1'b0;
    end else if (!cfg.gateOn) begin
      cnt      <= '0;
      clkEnOut <= 1'b0;
    end else begin
      clkEnOut <= parentHit && (endHit || midHit);
      if (parentHit) cnt <= endHit ? '0 : cnt + DIV_W'(1);
    end
  end

  // R2: the off entry yields no pulse
  p_src0_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.srcSel == '0) |=> !clkEnOut);

  // R3: a closed gate yields no pulse
  p_gate_off_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.gateOn |=> !clkEnOut);

  // R3: counter never passes the divisor
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.gateOn |-> (cnt <= cfg.divM1));
endmodule

// File: rtl/pclk_slot.sv
module pclk_slot
  import pclk_slot_pkg::*;
#(
  parameter bit HAS_SRC   = 1'b1,
  parameter bit HAS_DIV   = 1'b1,
  parameter int FIXED_SRC = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slotPresent,
  input  logic                 slotInUse,
  input  logic [SRC_COUNT-1:0] srcEnIn,
  input  logic                 busWe,
  input  logic                 busRe,
  input  logic [WORD_W-1:0]    busWdata,
  output logic [WORD_W-1:0]    busRdata,
  output logic                 clkEnOut,
  output logic                 periphRstN,
  output logic                 clkIsEnabled
);
  slotCfg_t cfg;

  pclk_slot_ctrl #(
    .HAS_SRC(HAS_SRC), .HAS_DIV(HAS_DIV), .FIXED_SRC(FIXED_SRC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .slotPresent(slotPresent), .slotInUse(slotInUse),
    .busWe(busWe), .busRe(busRe), .busWdata(busWdata), .busRdata(busRdata),
    .periphRstN(periphRstN), .clkIsEnabled(clkIsEnabled), .cfg(cfg)
  );

  pclk_slot_div u_div (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .srcEnIn(srcEnIn), .clkEnOut(clkEnOut)
  );
endmodule

// File: tb/tb_pclk_slot.sv
`timescale 1ns/1ps
module tb_pclk_slot;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slotPresent = 1'b1, slotInUse = 1'b0;
  logic [7:0]  srcEnIn = '0;
  logic        busWe = 0, busRe = 0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        clkEnOut, periphRstN, clkIsEnabled;
  logic        fWe = 0, fRe = 0;
  logic [31:0] fWdata = '0;
  logic [31:0] fRdata;
  logic        fOut, fRstN, fEn;

  always #5 clk = ~clk;

  pclk_slot dut (
    .clk(clk), .rst_n(rst_n), .slotPresent(slotPresent), .slotInUse(slotInUse),
    .srcEnIn(srcEnIn), .busWe(busWe), .busRe(busRe), .busWdata(busWdata),
    .busRdata(busRdata), .clkEnOut(clkEnOut), .periphRstN(periphRstN),
    .clkIsEnabled(clkIsEnabled));

  pclk_slot #(.HAS_SRC(1'b0), .HAS_DIV(1'b0), .FIXED_SRC(1)) dutFixed (
    .clk(clk), .rst_n(rst_n), .slotPresent(slotPresent), .slotInUse(slotInUse),
    .srcEnIn(srcEnIn), .busWe(fWe), .busRe(fRe), .busWdata(fWdata),
    .busRdata(fRdata), .clkEnOut(fOut), .periphRstN(fRstN), .clkIsEnabled(fEn));

  int nChecks = 0, nFails = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdIssued = 1'b0;

  function automatic logic [31:0] mk(bit g, bit r, int s, bit f, int d);
    return {1'b0, g, 1'b0, r, 1'b0, 3'(s), 20'b0, f, 3'(d)};
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); busWe = 1; busWdata = d;
    @(negedge clk); busWe = 0;
  endtask

  task automatic rd(logic [31:0] exp, string tag);
    @(negedge clk); busRe = 1; expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); busRe = 0;
  endtask

  // scoreboard monitor: read data is due the cycle after the strobe
  always @(posedge clk) rdIssued <= busRe;
  always @(negedge clk) begin
    if (rdIssued && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      chk(busRdata == e, t, busRdata, e);
    end
  end

  task automatic pulses(logic [7:0] mask, int n, int gap, bit useFixed,
                        output int cnt, output int first);
    int step = 0;
    cnt = 0; first = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (useFixed ? fOut : clkEnOut) begin cnt++; if (first < 0) first = step; end
      step++;
      srcEnIn = mask;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if (useFixed ? fOut : clkEnOut) begin cnt++; if (first < 0) first = step; end
        step++;
        srcEnIn = '0;
      end
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (useFixed ? fOut : clkEnOut) begin cnt++; if (first < 0) first = step; end
      step++;
      srcEnIn = '0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int c, f;
    logic [31:0] fd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(periphRstN == 0, "R1 reset output", periphRstN, 0);
    chk(clkEnOut == 0, "R1 no pulse", clkEnOut, 0);
    chk(clkIsEnabled == 0, "R10 idle status", clkIsEnabled, 0);
    rd(32'h8000_0000, "R1 reset word");

    wr(mk(0,1,5,0,2));
    rd(32'h9500_0002, "R9 config write");
    chk(periphRstN == 1, "R9 release", periphRstN, 1);
    wr(mk(1,1,5,0,2));
    rd(32'hD500_0002, "R6 gate on");
    chk(clkIsEnabled == 1, "R10 gate status", clkIsEnabled, 1);

    pulses(8'h08, 6, 0, 0, c, f);
    chk(c == 0, "R2 unselected input", c, 0);
    pulses(8'h20, 9, 0, 0, c, f);
    chk(c == 3, "R3 divide by 3 count", c, 3);
    chk(f == 3, "R3 divide by 3 timing", f, 3);

    wr(mk(1,1,5,0,7));
    rd(32'hDD00_0002, "R6 change under gate refused");
    rd(32'hD500_0002, "R8 flag cleared by read");

    wr(mk(0,1,5,0,2));
    wr(mk(0,1,5,1,2));
    rd(32'h9500_000A, "R4 frac write");
    wr(mk(1,1,5,1,2));
    pulses(8'h20, 9, 0, 0, c, f);
    chk(c == 6, "R4 frac N=3 count", c, 6);
    chk(f == 1, "R4 frac N=3 timing", f, 1);

    wr(mk(0,1,5,1,2));
    wr(mk(0,1,5,1,7));
    wr(mk(1,1,5,1,7));
    pulses(8'h20, 16, 1, 0, c, f);
    chk(c == 4, "R4 frac N=8 count", c, 4);
    chk(f == 7, "R4 frac N=8 timing", f, 7);

    wr(mk(0,1,5,1,7));
    wr(mk(0,1,5,1,0));
    rd(32'h9D00_000F, "R5 frac with divisor 1 refused");
    rd(32'h9500_000F, "R8 fields unchanged");

    wr(mk(0,1,5,0,7));
    wr(mk(1,1,5,0,7));
    pulses(8'h20, 16, 0, 0, c, f);
    chk(c == 2, "R3 divide by 8 count", c, 2);
    chk(f == 8, "R3 divide by 8 timing", f, 8);

    wr(mk(0,1,5,0,7));
    wr(mk(0,1,0,0,0));
    wr(mk(1,1,0,0,0));
    pulses(8'hFF, 5, 0, 0, c, f);
    chk(c == 0, "R2 source off", c, 0);

    wr(mk(0,1,0,0,0));
    wr(mk(0,1,1,0,0));
    wr(mk(1,1,1,0,0));
    pulses(8'h02, 5, 0, 0, c, f);
    chk(c == 5, "R3 divide by 1 count", c, 5);
    chk(f == 1, "R3 divide by 1 timing", f, 1);
    pulses(8'hFD, 5, 0, 0, c, f);
    chk(c == 0, "R2 other inputs ignored", c, 0);

    wr(mk(1,1,1,0,0) | 32'hA000_0000);
    rd(32'hD100_0000, "R11 read-only bits");

    @(negedge clk); slotInUse = 1;
    wr(mk(0,0,1,0,0));
    rd(32'hF900_0000, "R7 in-use refusal");
    chk(periphRstN == 1, "R8 reset output kept", periphRstN, 1);
    rd(32'hF100_0000, "R8 flag cleared");
    @(negedge clk); slotInUse = 0;
    wr(mk(0,1,1,0,0));
    rd(32'h9100_0000, "R6 gate off accepted");
    @(negedge clk); slotInUse = 1; #1;
    chk(clkIsEnabled == 1, "R10 in-use status", clkIsEnabled, 1);
    @(negedge clk); slotInUse = 0; #1;
    chk(clkIsEnabled == 0, "R10 status drops", clkIsEnabled, 0);

    @(negedge clk); slotPresent = 0;
    wr(mk(0,0,1,0,0));
    rd(32'h1900_0000, "R7 absent refusal");
    rd(32'h1100_0000, "R8 flag cleared again");
    @(negedge clk); slotPresent = 1;
    wr(mk(0,0,1,0,0));
    chk(periphRstN == 0, "R9 hold in reset", periphRstN, 0);

    // slot without source or divider fields
    @(negedge clk); fWe = 1; fWdata = mk(0,1,3,0,0);
    @(negedge clk); fWe = 0; fRe = 1;
    @(negedge clk); fRe = 0; fd = fRdata;
    chk(fd == 32'h8800_0000, "R12 source write refused", fd, 32'h8800_0000);
    @(negedge clk); fWe = 1; fWdata = mk(0,1,0,0,1);
    @(negedge clk); fWe = 0; fRe = 1;
    @(negedge clk); fRe = 0; fd = fRdata;
    chk(fd == 32'h8800_0000, "R12 divider write refused", fd, 32'h8800_0000);
    @(negedge clk); fWe = 1; fWdata = mk(1,1,0,0,0);
    @(negedge clk); fWe = 0;
    pulses(8'h02, 4, 0, 1, c, f);
    chk(c == 4, "R12 full rate on input 1", c, 4);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule